// File: doc/BRIEF.md
# DTMF Steering Qualifier and Digit Code Register

This block sits behind a dual-tone classifier. The classifier supplies a signal-condition flag and a 2-bit row index and a 2-bit column index. The block decides when a tone pair counts as a real keypress and when it has really ended. It uses two digital guard timers whose lengths are set in clock cycles, in place of an external RC network. Only a pair that is held without a break for the presence guard is registered. Only a silence that lasts for the absence guard releases the register. Shorter bursts and shorter dropouts therefore leave the outputs untouched.

On registration the pair is turned into a 4-bit digit code and written into a holding register. A delayed steering flag rises a fixed number of settling cycles later, so the code is already stable when the flag is seen. The code is driven onto a tri-state bus while the output enable is high. A separate enable copy is provided for simulation. Two further inputs change the behaviour. An inhibit input hides the fourth keypad column. A power-down input stops the steering logic and clears it.

Top module: `dtmf_steer`

## Requirements
- R1: While synchronous reset is high and after it, the delayed steering flag is 0 and the code register holds 0000.
- R2: A pair is registered only at the clock edge where the condition has been sampled high on PRES_CYC consecutive edges with the same row and column. A shorter burst leaves the code and the flag unchanged.
- R3: If the row or column changes while a pair is being qualified, the presence count restarts from one with the new pair.
- R4: After registration, the flag clears and a new pair can be accepted only when the condition has been sampled low on ABS_CYC consecutive edges. A shorter dropout keeps the flag and the code.
- R5: The code register changes on the registration edge. The delayed steering flag rises exactly SETTLE_CYC edges later, provided no release has happened by then.
- R6: Row index 0..3 selects the low-group tones from lowest to highest, and column index 0..3 does the same for the high group. The codes are as follows. Rows 0..2 with columns 0..2 give digits 1..9 as 0001..1001. Row 3 gives 1011 in column 0 (star), 1010 in column 1 (zero) and 1100 in column 2 (hash). Column 3 gives 1101, 1110 and 1111 for rows 0..2, and 0000 for row 3.
- R7: While inhibit is high, any pair in column 3 is treated as absent. It is not registered, early steering stays low, and the previous code is kept.
- R8: When the output enable is low, bus_oe is 0 and code_bus is high impedance. When it is high, code_bus equals code_raw. The code register updates whatever the enable is.
- R9: While power-down is high, early steering is 0. On the next edge the delayed flag is 0 and the qualifier is idle. The code register keeps its value.
- R10: early_steer is the signal condition after the inhibit mask, with no added register delay.
- R11: When the absence guard expires on the same edge as the settling delay, the release wins and the flag stays 0.
- R12: While a pair is registered and the condition stays high, a change of row or column is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down, halts and clears steering |
| sig_cond | input | 1 | Signal condition from the classifier |
| row_idx | input | 2 | Low-group tone index |
| col_idx | input | 2 | High-group tone index |
| inhibit | input | 1 | Hides column 3 pairs |
| out_en | input | 1 | Bus output enable |
| early_steer | output | 1 | Masked signal condition |
| dly_steer | output | 1 | Delayed steering flag |
| code_raw | output | 4 | Code register contents |
| bus_oe | output | 1 | Bus drive enable copy |
| code_bus | output | 4 | Tri-state code bus |

## Verification
The settling delay and the absence guard can end on the same edge. This happens when the condition drops on the first sample after registration and ABS_CYC equals SETTLE_CYC. The bench runs with both set to 6 so that this case occurs. It registers a pair and drops the tone at once, then requires the flag to stay low through the release edge. The random phase then mixes short bursts, dropouts and pair changes against a cycle model, so the coincidence also arises unplanned.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    localparam int IDX_W  = 2;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QPRES = 2'd1,
        ST_HELD  = 2'd2,
        ST_QABS  = 2'd3
    } steer_st_e;

    typedef struct packed {
        logic [IDX_W-1:0] row;
        logic [IDX_W-1:0] col;
    } key_pair_t;

    // Letter keys live in the highest column
    function automatic logic is_letter(key_pair_t kp);
        return kp.col == IDX_W'(3);
    endfunction

    function automatic logic [CODE_W-1:0] key_code(key_pair_t kp);
        logic [CODE_W-1:0] c;
        if (kp.col == IDX_W'(3)) begin
            c = (kp.row == IDX_W'(3)) ? CODE_W'(0) : CODE_W'(13) + CODE_W'(kp.row);
        end else if (kp.row == IDX_W'(3)) begin
            case (kp.col)
                IDX_W'(0): c = CODE_W'(11);
                IDX_W'(1): c = CODE_W'(10);
                default:   c = CODE_W'(12);
            endcase
        end else begin
            c = CODE_W'(kp.row) * CODE_W'(3) + CODE_W'(kp.col) + CODE_W'(1);
        end
        return c;
    endfunction

endpackage

// File: rtl/dtmf_guard_fsm.sv
module dtmf_guard_fsm
    import dtmf_steer_pkg::*;
#(
    parameter int PRES_CYC = 30000,
    parameter int ABS_CYC  = 30000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_dn,
    input  logic      cond,
    input  key_pair_t pair,
    output logic      latch_pls,
    output logic      release_pls,
    output key_pair_t pair_q,
    output steer_st_e st_q
);
    localparam int MAX_CYC = (PRES_CYC > ABS_CYC) ? PRES_CYC : ABS_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PRES_LAST = CNT_W'(PRES_CYC - 1);
    localparam logic [CNT_W-1:0] ABS_LAST  = CNT_W'(ABS_CYC - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             same_pair;

    assign same_pair   = (pair == pair_q);
    assign latch_pls   = !pwr_dn && (st_q == ST_QPRES) && cond && same_pair && (cnt_q == PRES_LAST);
    assign release_pls = !pwr_dn && (st_q == ST_QABS) && !cond && (cnt_q == ABS_LAST);

    always_ff @(posedge clk) begin
        if (rst || pwr_dn) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pair_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cond) begin
                        st_q   <= ST_QPRES;
                        cnt_q  <= ONE;
                        pair_q <= pair;
                    end
                end
                ST_QPRES: begin
                    if (!cond) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else if (!same_pair) begin
                        cnt_q  <= ONE;
                        pair_q <= pair;
                    end else if (cnt_q == PRES_LAST) begin
                        st_q  <= ST_HELD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                ST_HELD: begin
                    if (!cond) begin
                        st_q  <= ST_QABS;
                        cnt_q <= ONE;
                    end
                end
                default: begin
                    if (cond) begin
                        st_q  <= ST_HELD;
                        cnt_q <= '0;
                    end else if (cnt_q == ABS_LAST) begin
                        st_q  <= ST_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
            endcase
        end
    end

    // R3
    pair_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_QPRES && cond && !same_pair && !pwr_dn) |=> (st_q == ST_QPRES && cnt_q == ONE));

    // R12
    held_ignores_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HELD && cond && !pwr_dn) |=> (st_q == ST_HELD && $stable(pair_q)));

endmodule

// File: rtl/dtmf_settle_delay.sv
module dtmf_settle_delay #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic steer
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            steer  <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                steer  <= 1'b1;
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R11
    release_prio_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !steer);

endmodule

// File: rtl/dtmf_code_reg.sv
module dtmf_code_reg
    import dtmf_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  key_pair_t         pair,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= key_code(pair);
        end
    end
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
    import dtmf_steer_pkg::*;
#(
    parameter int PRES_CYC   = 30000,
    parameter int ABS_CYC    = 30000,
    parameter int SETTLE_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_dn,
    input  logic        sig_cond,
    input  logic [1:0]  row_idx,
    input  logic [1:0]  col_idx,
    input  logic        inhibit,
    input  logic        out_en,
    output logic        early_steer,
    output logic        dly_steer,
    output logic [3:0]  code_raw,
    output logic        bus_oe,
    output logic [3:0]  code_bus
);
    key_pair_t  in_pair;
    key_pair_t  held_pair;
    steer_st_e  fsm_st;
    logic       cond_eff;
    logic       latch_pls;
    logic       release_pls;

    assign in_pair.row = row_idx;
    assign in_pair.col = col_idx;
    assign cond_eff    = sig_cond && !(inhibit && is_letter(in_pair));
    assign early_steer = cond_eff && !pwr_dn;

    dtmf_guard_fsm #(
        .PRES_CYC (PRES_CYC),
        .ABS_CYC  (ABS_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_dn      (pwr_dn),
        .cond        (cond_eff),
        .pair        (in_pair),
        .latch_pls   (latch_pls),
        .release_pls (release_pls),
        .pair_q      (held_pair),
        .st_q        (fsm_st)
    );

    dtmf_code_reg u_code (
        .clk    (clk),
        .rst    (rst),
        .load   (latch_pls),
        .pair   (held_pair),
        .code_q (code_raw)
    );

    dtmf_settle_delay #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk   (clk),
        .rst   (rst),
        .clr   (release_pls || pwr_dn),
        .start (latch_pls),
        .steer (dly_steer)
    );

    assign bus_oe   = out_en;
    assign code_bus = out_en ? code_raw : 4'bzzzz;

    // R9
    pd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (!dly_steer && fsm_st == ST_IDLE));

    // R7
    inh_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (inhibit && col_idx == 2'd3) |-> !early_steer);

    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_pls |=> $stable(code_raw));

    // R5
    steer_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dly_steer) |-> (fsm_st == ST_HELD || fsm_st == ST_QABS));

    // R4
    steer_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dly_steer) |-> ($past(pwr_dn) || $past(rst) || $past(fsm_st) == ST_QABS));

endmodule

// File: tb/dtmf_steer_bench.sv
`timescale 1ns/1ps
module dtmf_steer_bench;
    localparam int PRES   = 10;
    localparam int ABSC   = 6;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_dn = 1'b0;
    logic       sig_cond = 1'b0;
    logic [1:0] row_idx = 2'd0;
    logic [1:0] col_idx = 2'd0;
    logic       inhibit = 1'b0;
    logic       out_en = 1'b1;
    logic       early_steer, dly_steer, bus_oe;
    logic [3:0] code_raw, code_bus;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R1";

    // reference model state
    bit       m_held, m_settling, m_dly;
    int       m_run, m_gap, m_since;
    bit [3:0] m_code;
    bit [1:0] m_r, m_c;

    always #2 clk = ~clk;

    dtmf_steer #(.PRES_CYC(PRES), .ABS_CYC(ABSC), .SETTLE_CYC(SETTLE)) u_dtmf_steer (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .sig_cond(sig_cond),
        .row_idx(row_idx), .col_idx(col_idx), .inhibit(inhibit), .out_en(out_en),
        .early_steer(early_steer), .dly_steer(dly_steer), .code_raw(code_raw),
        .bus_oe(bus_oe), .code_bus(code_bus)
    );

    function automatic bit [3:0] exp_code(bit [1:0] r, bit [1:0] c);
        if (c == 2'd3) return (r == 2'd3) ? 4'd0 : 4'd13 + 4'(r);
        if (r == 2'd3) begin
            if (c == 2'd0) return 4'd11;
            if (c == 2'd1) return 4'd10;
            return 4'd12;
        end
        return 4'(r) * 4'd3 + 4'(c) + 4'd1;
    endfunction

    function automatic bit exp_eff();
        return sig_cond && !(inhibit && col_idx == 2'd3);
    endfunction

    task automatic model_update();
        bit e;
        e = exp_eff();
        if (rst) begin
            m_held = 0; m_settling = 0; m_dly = 0; m_run = 0; m_gap = 0; m_since = 0; m_code = 0;
        end else if (pwr_dn) begin
            m_held = 0; m_settling = 0; m_dly = 0; m_run = 0; m_gap = 0;
        end else if (!m_held) begin
            if (e) begin
                if (m_run > 0 && row_idx == m_r && col_idx == m_c) m_run++;
                else begin m_run = 1; m_r = row_idx; m_c = col_idx; end
            end else m_run = 0;
            if (m_run == PRES) begin
                m_held = 1; m_code = exp_code(m_r, m_c); m_run = 0; m_gap = 0;
                m_since = 0; m_settling = 1;
            end
        end else begin
            if (e) m_gap = 0; else m_gap++;
            if (m_gap == ABSC) begin
                m_held = 0; m_gap = 0; m_dly = 0; m_settling = 0;
            end else if (m_settling) begin
                m_since++;
                if (m_since == SETTLE) begin m_dly = 1; m_settling = 0; end
            end
        end
    endtask

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("dly_steer", int'(dly_steer), int'(m_dly));
        chk("code_raw", int'(code_raw), int'(m_code));
        chk("early_steer", int'(early_steer), int'(exp_eff() && !pwr_dn));
        chk("bus_oe", int'(bus_oe), int'(out_en));
        if (out_en) chk("code_bus", int'(code_bus), int'(m_code));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare();
    endtask

    task automatic hold(bit s, bit [1:0] r, bit [1:0] c, int n);
        sig_cond = s; row_idx = r; col_idx = c;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1 reset state
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) step();
        chk("reset dly", int'(dly_steer), 0);
        chk("reset code", int'(code_raw), 0);
        rst = 1'b0;
        step();

        // R2 one short of the guard, then exactly the guard
        cur_tag = "R2";
        hold(1, 2'd0, 2'd0, PRES - 1);
        chk("short burst code", int'(code_raw), 0);
        hold(1, 2'd0, 2'd0, 1);
        chk("guard met code", int'(code_raw), 1);
        // R5 flag rises SETTLE edges after registration
        cur_tag = "R5";
        hold(1, 2'd0, 2'd0, SETTLE - 1);
        chk("before settle", int'(dly_steer), 0);
        hold(1, 2'd0, 2'd0, 1);
        chk("after settle", int'(dly_steer), 1);
        // R4 dropout tolerance and release
        cur_tag = "R4";
        hold(0, 2'd0, 2'd0, ABSC - 1);
        chk("short dropout dly", int'(dly_steer), 1);
        hold(1, 2'd0, 2'd0, 1);
        hold(0, 2'd0, 2'd0, ABSC);
        chk("release dly", int'(dly_steer), 0);
        chk("release keeps code", int'(code_raw), 1);

        // R3 pair change restarts qualification
        cur_tag = "R3";
        hold(1, 2'd1, 2'd1, PRES - 4);
        hold(1, 2'd2, 2'd2, PRES - 1);
        chk("restart no latch", int'(code_raw), 1);
        hold(1, 2'd2, 2'd2, 1);
        chk("restart latch", int'(code_raw), 9);
        hold(1, 2'd2, 2'd2, SETTLE);

        // R12 pair change while registered ignored
        cur_tag = "R12";
        hold(1, 2'd3, 2'd1, 3 * PRES);
        chk("held pair change", int'(code_raw), 9);
        hold(0, 2'd0, 2'd0, ABSC);

        // R11 release and settle on the same edge
        cur_tag = "R11";
        hold(1, 2'd0, 2'd1, PRES);
        chk("coincide latch", int'(code_raw), 2);
        hold(0, 2'd0, 2'd1, ABSC);
        chk("coincide dly", int'(dly_steer), 0);

        // R7 inhibit hides column 3
        cur_tag = "R7";
        inhibit = 1'b1;
        hold(1, 2'd0, 2'd3, 2 * PRES);
        chk("inhibited code", int'(code_raw), 2);
        chk("inhibited early", int'(early_steer), 0);
        // R10 early steering follows the masked condition
        cur_tag = "R10";
        inhibit = 1'b0;
        sig_cond = 1'b1; #1;
        chk("early immediate", int'(early_steer), 1);
        hold(1, 2'd0, 2'd3, PRES);
        chk("uninhibited code", int'(code_raw), 13);
        hold(0, 2'd0, 2'd0, ABSC);

        // R6 full code map
        cur_tag = "R6";
        for (int k = 0; k < 16; k++) begin
            hold(1, 2'(k / 4), 2'(k % 4), PRES);
            chk("map", int'(code_raw), int'(exp_code(2'(k / 4), 2'(k % 4))));
            hold(0, 2'd0, 2'd0, ABSC);
        end

        // R8 enable low, register still updates
        cur_tag = "R8";
        out_en = 1'b0;
        hold(1, 2'd1, 2'd2, PRES);
        chk("oe low", int'(bus_oe), 0);
        chk("update hidden", int'(code_raw), 6);
        out_en = 1'b1; #1;
        chk("bus shows code", int'(code_bus), 6);
        hold(1, 2'd1, 2'd2, SETTLE);

        // R9 power-down clears steering, keeps code
        cur_tag = "R9";
        pwr_dn = 1'b1;
        hold(1, 2'd1, 2'd2, 2);
        chk("pd dly", int'(dly_steer), 0);
        chk("pd early", int'(early_steer), 0);
        chk("pd code", int'(code_raw), 6);
        pwr_dn = 1'b0;
        hold(0, 2'd0, 2'd0, ABSC);

        // Random segments against the model
        cur_tag = "R2_R4_rand";
        for (int seg = 0; seg < 1500; seg++) begin
            inhibit = ($urandom_range(0, 3) == 0);
            out_en  = ($urandom_range(0, 3) != 0);
            pwr_dn  = ($urandom_range(0, 60) == 0);
            hold(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), $urandom_range(1, 14));
        end
        pwr_dn = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule